// File: doc/BRIEF.md
# Multi-Cycle Shared-Resource Processor Datapath

This block is the datapath of a 32-bit processor that runs each instruction over three to five clock cycles. It supports register-to-register add, subtract, AND, OR and signed set-less-than, word load, word store, branch-if-equal and an absolute jump. It has one memory port, which serves both instruction fetch and data access, and one ALU. The ALU computes the next sequential PC, the branch target, the load/store address and the arithmetic results. Between cycles, values are held in five internal registers: the instruction register, two operand latches (A, B), a memory data latch and an ALU result latch. The architectural state is a 32-entry register file plus the PC.

The block contains no sequencing logic. An external controller drives every select and enable each cycle, and it reads back the opcode, the function field and the ALU zero flag. The memory sits outside the block. It returns read data in the same cycle as the address and takes writes on the rising edge.

Top module: `mcd_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, the PC and all five holding registers become zero on that edge. After such an edge, `pc_o`, `opcode_o` and `funct_o` read zero.
- R2: Select encodings:
  - `ctl_iord` 0 puts the PC on `mem_addr_o`; 1 puts the ALU result latch there.
  - `ctl_alu_a_sel` 0 feeds the PC to the ALU; 1 feeds A.
  - `ctl_alu_b_sel` feeds B (00), the constant 4 (01), the sign-extended IR[15:0] (10), or that value shifted left by 2 (11).
  - `ctl_pc_src` loads the PC from the live ALU result (00), the ALU result latch (01), or the jump address (10).
  - `ctl_reg_dst` 0 writes to the register named by IR[20:16]; 1 writes to IR[15:11].
  - `ctl_mem_to_reg` 0 writes the ALU result latch; 1 writes the memory data latch.
- R3: Fetch cycle: with `ctl_ir_wr` high, the IR loads `mem_rdata_i`. In the same cycle, PC+4 computed by the ALU is loaded into the PC.
- R4: A and B load the registers named by IR[25:21] and IR[20:16] every cycle. The ALU result latch loads the ALU output every cycle, so during decode it can capture PC + (sext(IR[15:0]) << 2).
- R5: `ctl_alu_op` encodings are 000 AND, 001 OR, 010 add, 110 subtract and 111 signed set-less-than (result 1 or 0). A register-form instruction writes its result to IR[15:11]. The function codes are 0x20 add, 0x22 sub, 0x24 and, 0x25 or and 0x2A slt, under opcode 0x00.
- R6: Load (opcode 0x23): the address is A + sext(IR[15:0]). The memory data latch captures the word, and a final cycle writes it to IR[20:16].
- R7: Store (opcode 0x2B): the word at the address held in the ALU result latch is written with B. `mem_we_o` and `mem_re_o` follow `ctl_mem_wr` and `ctl_mem_rd`.
- R8: Branch-if-equal (opcode 0x04): the ALU computes A−B and `zero_o` is high exactly when the result is zero. With `ctl_pc_wr_cond` high, the PC loads the earlier computed target only when `zero_o` is high.
- R9: Jump (opcode 0x02): the PC becomes the top four bits of the PC, then IR[25:0], then two zero bits.
- R10: Register 0 always reads as zero, and writes to it are dropped.
- R11: The PC changes only when `ctl_pc_wr` is high, or when `ctl_pc_wr_cond` and `zero_o` are both high. The IR changes only when `ctl_ir_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctl_mem_rd | input | 1 | Memory read request |
| ctl_mem_wr | input | 1 | Memory write request |
| ctl_iord | input | 1 | Memory address select |
| ctl_ir_wr | input | 1 | Instruction register load |
| ctl_pc_wr | input | 1 | Unconditional PC load |
| ctl_pc_wr_cond | input | 1 | PC load when ALU result is zero |
| ctl_pc_src | input | 2 | PC source select |
| ctl_alu_a_sel | input | 1 | ALU first operand select |
| ctl_alu_b_sel | input | 2 | ALU second operand select |
| ctl_alu_op | input | 3 | ALU operation |
| ctl_reg_wr | input | 1 | Register file write enable |
| ctl_reg_dst | input | 1 | Destination register field select |
| ctl_mem_to_reg | input | 1 | Register write data select |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| opcode_o | output | 6 | IR[31:26] to the controller |
| funct_o | output | 6 | IR[5:0] to the controller |
| zero_o | output | 1 | ALU result is zero |
| pc_o | output | 32 | Current PC |

## Verification
The bench steers taken and untaken branches with equal and unequal operands. A design that took the live ALU result instead of the stored target, or that ignored the zero flag, would land on the wrong PC. Set-less-than is driven with a negative operand against a positive one, where an unsigned compare gives the opposite answer. Register 0 is written by register-form instructions and loads, then stored, so a design that stored into entry 0 would write a nonzero word. Loads and stores use random base registers and negative offsets, which exposes a missing sign extension or a swapped destination field. Jumps from PCs with random upper bits catch a jump address that drops the top nibble.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    localparam int XLEN    = 32;
    localparam int NREGS   = 32;
    localparam int RIDX_W  = $clog2(NREGS);
    localparam int IMM_W   = 16;
    localparam int JIDX_W  = 26;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        OPB_REG   = 2'b00,
        OPB_FOUR  = 2'b01,
        OPB_IMM   = 2'b10,
        OPB_IMMSH = 2'b11
    } opb_sel_e;

    typedef enum logic [1:0] {
        PCS_ALU  = 2'b00,
        PCS_LAT  = 2'b01,
        PCS_JUMP = 2'b10
    } pc_src_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] opa;
        logic [XLEN-1:0] opb;
        logic [XLEN-1:0] mdr;
        logic [XLEN-1:0] res;
    } hold_t;

endpackage

// File: rtl/mcd_alu.sv
module mcd_alu
    import mcd_pkg::*;
#(
    parameter int WIDTH = XLEN
) (
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic [WIDTH-1:0] result,
    output logic             is_zero
);

    always_comb begin
        case (alu_op_e'(op))
            ALU_AND: result = in_a & in_b;
            ALU_OR:  result = in_a | in_b;
            ALU_ADD: result = in_a + in_b;
            ALU_SUB: result = in_a - in_b;
            ALU_SLT: result = {{(WIDTH-1){1'b0}}, ($signed(in_a) < $signed(in_b))};
            default: result = '0;
        endcase
        is_zero = (result == '0);
    end

endmodule

// File: rtl/mcd_opsel.sv
module mcd_opsel
    import mcd_pkg::*;
#(
    parameter int WIDTH = XLEN,
    parameter int IW    = IMM_W
) (
    input  logic             a_sel,
    input  logic [1:0]       b_sel,
    input  logic [WIDTH-1:0] pc,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [IW-1:0]    imm,
    output logic [WIDTH-1:0] alu_a,
    output logic [WIDTH-1:0] alu_b
);

    localparam int EXT_W = WIDTH - IW;

    logic [WIDTH-1:0] imm_ext;
    logic [WIDTH-1:0] imm_ext_sh;

    always_comb begin
        imm_ext    = {{EXT_W{imm[IW-1]}}, imm};
        imm_ext_sh = {imm_ext[WIDTH-3:0], 2'b00};
        alu_a      = a_sel ? opa : pc;
        case (opb_sel_e'(b_sel))
            OPB_REG:   alu_b = opb;
            OPB_FOUR:  alu_b = WIDTH'(4);
            OPB_IMM:   alu_b = imm_ext;
            OPB_IMMSH: alu_b = imm_ext_sh;
            default:   alu_b = opb;
        endcase
    end

endmodule

// File: rtl/mcd_regfile.sv
module mcd_regfile
#(
    parameter int NR    = 32,
    parameter int WIDTH = 32,
    parameter int AW    = $clog2(NR)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    rd0_addr,
    input  logic [AW-1:0]    rd1_addr,
    output logic [WIDTH-1:0] rd0_data,
    output logic [WIDTH-1:0] rd1_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data
);

    logic [WIDTH-1:0] regs_q [NR];
    logic [WIDTH-1:0] regs_d [NR];

    // entry 0 is never written and always reads zero
    always_comb begin
        regs_d = regs_q;
        if (wr_en && (wr_addr != '0)) begin
            regs_d[wr_addr] = wr_data;
        end
        if (rst) begin
            for (int i = 0; i < NR; i++) begin
                regs_d[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign rd0_data = (rd0_addr == '0) ? '0 : regs_q[rd0_addr];
    assign rd1_data = (rd1_addr == '0) ? '0 : regs_q[rd1_addr];

endmodule

// File: rtl/mcd_datapath.sv
module mcd_datapath
    import mcd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_mem_rd,
    input  logic        ctl_mem_wr,
    input  logic        ctl_iord,
    input  logic        ctl_ir_wr,
    input  logic        ctl_pc_wr,
    input  logic        ctl_pc_wr_cond,
    input  logic [1:0]  ctl_pc_src,
    input  logic        ctl_alu_a_sel,
    input  logic [1:0]  ctl_alu_b_sel,
    input  logic [2:0]  ctl_alu_op,
    input  logic        ctl_reg_wr,
    input  logic        ctl_reg_dst,
    input  logic        ctl_mem_to_reg,
    output logic [31:0] mem_addr_o,
    output logic [31:0] mem_wdata_o,
    input  logic [31:0] mem_rdata_i,
    output logic        mem_re_o,
    output logic        mem_we_o,
    output logic [5:0]  opcode_o,
    output logic [5:0]  funct_o,
    output logic        zero_o,
    output logic [31:0] pc_o
);

    hold_t hold_q;
    hold_t hold_d;

    logic [XLEN-1:0]   alu_a;
    logic [XLEN-1:0]   alu_b;
    logic [XLEN-1:0]   alu_y;
    logic              alu_zero;
    logic [XLEN-1:0]   rf_rd0;
    logic [XLEN-1:0]   rf_rd1;
    logic [RIDX_W-1:0] rf_wr_addr;
    logic [XLEN-1:0]   rf_wr_data;
    logic [XLEN-1:0]   jump_target;
    logic              pc_load;

    // operand steering into the single shared ALU
    mcd_opsel #(.WIDTH(XLEN), .IW(IMM_W)) u_opsel (
        .a_sel (ctl_alu_a_sel),
        .b_sel (ctl_alu_b_sel),
        .pc    (hold_q.pc),
        .opa   (hold_q.opa),
        .opb   (hold_q.opb),
        .imm   (hold_q.ir[IMM_W-1:0]),
        .alu_a (alu_a),
        .alu_b (alu_b)
    );

    mcd_alu #(.WIDTH(XLEN)) u_alu (
        .op      (ctl_alu_op),
        .in_a    (alu_a),
        .in_b    (alu_b),
        .result  (alu_y),
        .is_zero (alu_zero)
    );

    always_comb begin
        rf_wr_addr = ctl_reg_dst ? hold_q.ir[15:11] : hold_q.ir[20:16];
        rf_wr_data = ctl_mem_to_reg ? hold_q.mdr : hold_q.res;
    end

    mcd_regfile #(.NR(NREGS), .WIDTH(XLEN), .AW(RIDX_W)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd0_addr (hold_q.ir[25:21]),
        .rd1_addr (hold_q.ir[20:16]),
        .rd0_data (rf_rd0),
        .rd1_data (rf_rd1),
        .wr_en    (ctl_reg_wr),
        .wr_addr  (rf_wr_addr),
        .wr_data  (rf_wr_data)
    );

    // next-state for every holding register
    always_comb begin
        hold_d      = hold_q;
        jump_target = {hold_q.pc[XLEN-1:XLEN-4], hold_q.ir[JIDX_W-1:0], 2'b00};
        pc_load     = ctl_pc_wr | (ctl_pc_wr_cond & alu_zero);

        if (pc_load) begin
            case (pc_src_e'(ctl_pc_src))
                PCS_ALU:  hold_d.pc = alu_y;
                PCS_LAT:  hold_d.pc = hold_q.res;
                PCS_JUMP: hold_d.pc = jump_target;
                default:  hold_d.pc = hold_q.pc;
            endcase
        end

        if (ctl_ir_wr) begin
            hold_d.ir = mem_rdata_i;
        end

        hold_d.opa = rf_rd0;
        hold_d.opb = rf_rd1;
        hold_d.mdr = mem_rdata_i;
        hold_d.res = alu_y;

        if (rst) begin
            hold_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        hold_q <= hold_d;
    end

    always_comb begin
        mem_addr_o  = ctl_iord ? hold_q.res : hold_q.pc;
        mem_wdata_o = hold_q.opb;
        mem_re_o    = ctl_mem_rd;
        mem_we_o    = ctl_mem_wr;
        opcode_o    = hold_q.ir[31:26];
        funct_o     = hold_q.ir[5:0];
        zero_o      = alu_zero;
        pc_o        = hold_q.pc;
    end

endmodule

// File: rtl/mcd_datapath_chk.sv
module mcd_datapath_chk (
    input logic        clk,
    input logic        rst,
    input logic        ctl_ir_wr,
    input logic        ctl_pc_wr,
    input logic        ctl_pc_wr_cond,
    input logic [1:0]  ctl_pc_src,
    input logic        ctl_alu_a_sel,
    input logic [1:0]  ctl_alu_b_sel,
    input logic [2:0]  ctl_alu_op,
    input logic [5:0]  opcode_o,
    input logic [5:0]  funct_o,
    input logic        zero_o,
    input logic [31:0] pc_o
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (pc_o == 32'd0 && opcode_o == 6'd0 && funct_o == 6'd0));

    assert_fetch_incr_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl_pc_wr && ctl_pc_src == 2'b00 && !ctl_alu_a_sel &&
         ctl_alu_b_sel == 2'b01 && ctl_alu_op == 3'b010)
        |=> pc_o == $past(pc_o) + 32'd4);

    assert_pc_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!ctl_pc_wr && !ctl_pc_wr_cond) |=> $stable(pc_o));

    assert_branch_untaken_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl_pc_wr_cond && !ctl_pc_wr && !zero_o) |=> $stable(pc_o));

    assert_jump_region_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl_pc_wr && ctl_pc_src == 2'b10)
        |=> (pc_o[1:0] == 2'b00 && pc_o[31:28] == $past(pc_o[31:28])));

    assert_ir_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !ctl_ir_wr |=> $stable({opcode_o, funct_o}));

endmodule

bind mcd_datapath mcd_datapath_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .ctl_ir_wr      (ctl_ir_wr),
    .ctl_pc_wr      (ctl_pc_wr),
    .ctl_pc_wr_cond (ctl_pc_wr_cond),
    .ctl_pc_src     (ctl_pc_src),
    .ctl_alu_a_sel  (ctl_alu_a_sel),
    .ctl_alu_b_sel  (ctl_alu_b_sel),
    .ctl_alu_op     (ctl_alu_op),
    .opcode_o       (opcode_o),
    .funct_o        (funct_o),
    .zero_o         (zero_o),
    .pc_o           (pc_o)
);

// File: tb/mcd_datapath_tb_top.sv
module mcd_datapath_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 64;
    localparam int N_RANDOM   = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_mem_rd, ctl_mem_wr, ctl_iord, ctl_ir_wr;
    logic        ctl_pc_wr, ctl_pc_wr_cond;
    logic [1:0]  ctl_pc_src;
    logic        ctl_alu_a_sel;
    logic [1:0]  ctl_alu_b_sel;
    logic [2:0]  ctl_alu_op;
    logic        ctl_reg_wr, ctl_reg_dst, ctl_mem_to_reg;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic        mem_re_o, mem_we_o;
    logic [5:0]  opcode_o, funct_o;
    logic        zero_o;
    logic [31:0] pc_o;

    logic [31:0] mem     [MEM_WORDS];
    logic [31:0] exp_mem [MEM_WORDS];
    logic [31:0] exp_rf  [32];
    logic [31:0] exp_pc;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcd_datapath dut_i (.*);

    assign mem_rdata_i = mem[mem_addr_o[7:2]];

    always @(posedge clk) begin
        if (mem_we_o) mem[mem_addr_o[7:2]] <= mem_wdata_o;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic ctl_idle();
        ctl_mem_rd = 0; ctl_mem_wr = 0; ctl_iord = 0; ctl_ir_wr = 0;
        ctl_pc_wr = 0; ctl_pc_wr_cond = 0; ctl_pc_src = 2'b00;
        ctl_alu_a_sel = 0; ctl_alu_b_sel = 2'b00; ctl_alu_op = 3'b010;
        ctl_reg_wr = 0; ctl_reg_dst = 0; ctl_mem_to_reg = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        ctl_idle();
    endtask

    function automatic logic [31:0] sext(logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] ref_alu(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
        case (fn)
            6'h20: return a + b;
            6'h22: return a - b;
            6'h24: return a & b;
            6'h25: return a | b;
            default: return {31'd0, $signed(a) < $signed(b)};
        endcase
    endfunction

    function automatic logic [2:0] alu_code(logic [5:0] fn);
        case (fn)
            6'h20: return 3'b010;
            6'h22: return 3'b110;
            6'h24: return 3'b000;
            6'h25: return 3'b001;
            default: return 3'b111;
        endcase
    endfunction

    function automatic logic [31:0] mk_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] mk_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    // places the instruction at the current PC, sequences it and checks the result
    task automatic run(logic [31:0] ins);
        logic [5:0]  op  = ins[31:26];
        logic [4:0]  rs  = ins[25:21];
        logic [4:0]  rt  = ins[20:16];
        logic [4:0]  rd  = ins[15:11];
        logic [5:0]  fn  = ins[5:0];
        logic [31:0] pc4 = exp_pc + 32'd4;
        logic [31:0] addr;
        mem[exp_pc[7:2]]     = ins;
        exp_mem[exp_pc[7:2]] = ins;
        // R3 fetch
        ctl_mem_rd = 1; ctl_ir_wr = 1; ctl_alu_b_sel = 2'b01; ctl_pc_wr = 1;
        tick();
        // R4 decode: target into result latch
        ctl_alu_b_sel = 2'b11;
        tick();
        case (op)
            6'h00: begin // R5
                ctl_alu_a_sel = 1; ctl_alu_op = alu_code(fn);
                tick();
                ctl_reg_wr = 1; ctl_reg_dst = 1;
                tick();
                if (rd != 0) exp_rf[rd] = ref_alu(fn, exp_rf[rs], exp_rf[rt]);
                exp_pc = pc4;
                check("R3/R5 pc", pc_o, exp_pc);
            end
            6'h23: begin // R6
                addr = exp_rf[rs] + sext(ins[15:0]);
                ctl_alu_a_sel = 1; ctl_alu_b_sel = 2'b10;
                tick();
                ctl_mem_rd = 1; ctl_iord = 1;
                tick();
                ctl_reg_wr = 1; ctl_mem_to_reg = 1;
                tick();
                if (rt != 0) exp_rf[rt] = exp_mem[addr[7:2]];
                exp_pc = pc4;
                check("R6 pc", pc_o, exp_pc);
            end
            6'h2B: begin // R7
                addr = exp_rf[rs] + sext(ins[15:0]);
                ctl_alu_a_sel = 1; ctl_alu_b_sel = 2'b10;
                tick();
                ctl_mem_wr = 1; ctl_iord = 1;
                #1;
                check("R7 write strobe", {31'd0, mem_we_o}, 32'd1);
                tick();
                exp_mem[addr[7:2]] = exp_rf[rt];
                exp_pc = pc4;
                check("R7 stored word", mem[addr[7:2]], exp_mem[addr[7:2]]);
            end
            6'h04: begin // R8
                ctl_alu_a_sel = 1; ctl_alu_op = 3'b110; ctl_pc_wr_cond = 1; ctl_pc_src = 2'b01;
                #1;
                check("R8 zero flag", {31'd0, zero_o}, {31'd0, exp_rf[rs] == exp_rf[rt]});
                tick();
                exp_pc = (exp_rf[rs] == exp_rf[rt]) ? pc4 + {sext(ins[15:0])[29:0], 2'b00} : pc4;
                check("R8 branch pc", pc_o, exp_pc);
            end
            default: begin // R9 jump
                ctl_pc_wr = 1; ctl_pc_src = 2'b10;
                tick();
                exp_pc = {pc4[31:28], ins[25:0], 2'b00};
                check("R9 jump pc", pc_o, exp_pc);
            end
        endcase
    endtask

    function automatic logic [31:0] rand_ins();
        int unsigned kind = $urandom_range(0, 9);
        logic [4:0] rs = 5'($urandom_range(0, 31));
        logic [4:0] rt = 5'($urandom_range(0, 31));
        logic [4:0] rd = 5'($urandom_range(0, 31));
        logic [5:0] fns [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
        logic [15:0] imm = 16'($urandom);
        if (kind <= 3) return mk_r(rs, rt, rd, fns[$urandom_range(0, 4)]);
        if (kind <= 5) return mk_i(6'h23, rs, rt, imm);
        if (kind == 6) return mk_i(6'h2B, rs, rt, imm);
        if (kind <= 8) return mk_i(6'h04, rs, ($urandom_range(0, 1) == 1) ? rs : rt, imm);
        return {6'h02, 26'($urandom)};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        ctl_idle();
        for (int i = 0; i < MEM_WORDS; i++) begin
            mem[i] = (i >= 32) ? $urandom : 32'd0;
            exp_mem[i] = mem[i];
        end
        mem[33] = mem[32] + 32'd1; exp_mem[33] = mem[33];
        mem[34] = 32'h8000_0005;   exp_mem[34] = mem[34];
        mem[35] = 32'h0000_0003;   exp_mem[35] = mem[35];
        for (int i = 0; i < 32; i++) exp_rf[i] = 32'd0;
        exp_pc = 32'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 pc", pc_o, 32'd0);
        check("R1 opcode", {26'd0, opcode_o}, 32'd0);
        check("R1 funct", {26'd0, funct_o}, 32'd0);

        // directed corner cases
        run(mk_i(6'h23, 5'd0, 5'd1, 16'd128));         // r1 <- word 32
        run(mk_i(6'h23, 5'd0, 5'd2, 16'd132));         // r2 <- word 33 (differs)
        run(mk_i(6'h04, 5'd1, 5'd2, 16'd5));           // R8 untaken
        run(mk_i(6'h04, 5'd1, 5'd1, 16'hFFFD));        // R8 taken, backward
        run(mk_i(6'h23, 5'd0, 5'd5, 16'd136));         // negative value
        run(mk_i(6'h23, 5'd0, 5'd6, 16'd140));         // small positive
        run(mk_r(5'd5, 5'd6, 5'd7, 6'h2A));            // R5 signed slt -> 1
        run(mk_r(5'd6, 5'd5, 5'd8, 6'h2A));            // R5 signed slt -> 0
        run(mk_i(6'h2B, 5'd0, 5'd7, 16'd144));
        check("R5 slt negative vs positive", mem[36], 32'd1);
        run(mk_i(6'h2B, 5'd0, 5'd8, 16'd148));
        check("R5 slt positive vs negative", mem[37], 32'd0);
        run(mk_r(5'd1, 5'd2, 5'd0, 6'h20));            // R10 write to r0 dropped
        run(mk_i(6'h23, 5'd0, 5'd0, 16'd128));         // R10 load into r0 dropped
        run(mk_i(6'h2B, 5'd0, 5'd0, 16'd152));
        check("R10 r0 stays zero", mem[38], 32'd0);
        run(mk_i(6'h2B, 5'd5, 5'd1, 16'h0010));        // R6/R7 register base
        run({6'h02, 26'h3FF_FFF0});                    // R9 jump
        run(mk_i(6'h2B, 5'd1, 5'd2, 16'hFFF0));        // negative offset

        for (int n = 0; n < N_RANDOM; n++) run(rand_ins());

        // dump every register through stores (R4, R5, R6, R10)
        for (int i = 0; i < 32; i++) begin
            run(mk_i(6'h2B, 5'd0, 5'(i), 16'(128 + 4 * i)));
            check((i == 0) ? "R10 dump r0" : "R5/R6 dump reg", mem[32 + i], exp_rf[i]);
        end
        for (int i = 0; i < MEM_WORDS; i++) check("R7 memory image", mem[i], exp_mem[i]);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule